// File: doc/BRIEF.md
# Programmable Three-Channel Color Matrix Converter

The block converts a stream of three-component pixels, one per clock, through a programmable 3x3 matrix. The usual job is turning luma/chroma samples into red, green and blue. Before the multiply, each input component is shifted by a signed offset. Each output component is then formed as the dot product of one coefficient row with the shifted inputs, plus a signed per-row constant. The sum is rounded to the nearest integer and clamped to the unsigned output range. Pixels enter and leave on a valid-qualified stream with a fixed three-cycle latency. When conversion is switched off, samples come out unchanged with that same latency.

Software programs twelve 32-bit coefficient words and one enable bit through a simple write port. Writes land in a staging copy. A commit strobe requests that the staging copy be moved into the working copy. The move happens only on a cycle when no pixel is entering the pipeline or travelling through it, so a pixel is never computed with a mix of old and new settings. Swapping the two chroma inputs needs no special mode: software exchanges the words at column positions 1 and 2 of each row.

Top module: `csc_matrix`

## Requirements
- R1: After a synchronous active-low reset, out_valid is 0, all three outputs are 0, every coefficient word and the enable bit are 0, and pixels therefore pass through unconverted.
- R2: Each pixel accepted with in_valid high appears on the outputs with out_valid high exactly three clock edges later. Back-to-back pixels stream at one per clock, and out_valid is low in every cycle that does not carry a result.
- R3: The enable bit is bit 0 of the word at address 12. While it is 0, each output equals the matching input, with the same latency as converted pixels.
- R4: The word at address 4r+c, for c in 0..2, is the signed gain applied to input c for output r. Gains are two's complement with 17 fractional bits, so 0x00020000 is a gain of 1.0.
- R5: Bits 31:16 of the word at address 4k+3 hold a signed offset. This offset is added to input k before multiplication, and it is shared by all three output rows.
- R6: Bits 15:0 of the word at address 4r+3 hold a signed constant, in output LSB units, that is added to the sum for output r.
- R7: Results are rounded half-up: out = floor(sum + 0.5).
- R8: Results below 0 are output as 0, and results above 1023 are output as 1023.
- R9: Writes change only the staging copy. A cfg_commit pulse copies the staging copy into the working copy on the first clock edge where in_valid is low and no pixel is inside the pipeline. If a commit arrives while pixels are flowing, it is held until that point.
- R10: All twelve coefficient words are independently writable, so exchanging the column 1 and column 2 words of a row swaps which input each gain applies to.
- R11: Writes to addresses 13 to 15 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the staging registers |
| cfg_addr | input | 4 | Word address: 0..11 coefficients, 12 control |
| cfg_wdata | input | 32 | Write data |
| cfg_commit | input | 1 | Request to move the staging copy into the working copy |
| in_valid | input | 1 | Input pixel qualifier |
| in_c0 | input | 10 | Input component 0 (unsigned) |
| in_c1 | input | 10 | Input component 1 (unsigned) |
| in_c2 | input | 10 | Input component 2 (unsigned) |
| out_valid | output | 1 | Output pixel qualifier |
| out_c0 | output | 10 | Output component 0 |
| out_c1 | output | 10 | Output component 1 |
| out_c2 | output | 10 | Output component 2 |

## Verification
One fixed program combines a luma offset, a half gain, a negative gain, a double gain and positive and negative constants. Table vectors run against it so that odd inputs land exactly on rounding halves and the extremes saturate at both ends; this separates rounding errors from clamping errors and from errors in where the offset is applied. A limited-range luma/chroma program with gray and colored pixels checks that the offsets from the three rows reach the right inputs. A column swap shows that the gains are routed per column. A commit issued in the middle of a stream shows that old settings hold until the pipeline drains. Single pixels sent in bypass and back-to-back bursts pin down the latency and valid timing.

// File: rtl/csc_pkg.sv
// Shared constants and types for the colour matrix converter.
package csc_pkg;
    localparam int unsigned CSC_CH       = 3;                 // components per pixel
    localparam int unsigned CSC_COLS     = 4;                 // words per row: 3 gains + packed offset/constant
    localparam int unsigned CSC_NREG     = CSC_CH * CSC_COLS; // coefficient words
    localparam int unsigned CSC_CTRL_IDX = CSC_NREG;          // control word sits after the coefficients

    typedef enum logic [0:0] {
        CSC_PASS  = 1'b0,
        CSC_APPLY = 1'b1
    } csc_mode_e;
endpackage

// File: rtl/csc_regbank.sv
// Staging and working copies of the twelve coefficient words and the enable bit.
// Writes go to staging. A commit request moves staging into the working copy
// on the first edge where the pixel pipeline is idle (busy low). Assumes busy
// covers the input port and every pipeline stage that reads the working copy.
module csc_regbank
    import csc_pkg::*;
#(
    parameter int COEF_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                wr_addr,
    input  logic [COEF_W-1:0]                wr_data,
    input  logic                             commit,
    input  logic                             busy,
    output logic [CSC_NREG-1:0][COEF_W-1:0]  act_word,
    output csc_mode_e                        act_mode
);
    logic [CSC_NREG-1:0][COEF_W-1:0] stg_word;
    csc_mode_e                       stg_mode;
    logic                            pend_q;
    logic                            apply;

    assign apply = (pend_q | commit) & ~busy;

    // Staging copy: capture writes to decoded coefficient and control addresses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_word <= '0;
            stg_mode <= CSC_PASS;
        end else if (wr_en) begin
            for (int i = 0; i < CSC_NREG; i++) begin
                if (wr_addr == ADDR_W'(i)) stg_word[i] <= wr_data;
            end
            if (wr_addr == ADDR_W'(CSC_CTRL_IDX)) stg_mode <= csc_mode_e'(wr_data[0]);
        end
    end

    // Working copy: hold a commit request and apply it once the pipeline is empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_word <= '0;
            act_mode <= CSC_PASS;
            pend_q   <= 1'b0;
        end else begin
            if (commit) pend_q <= 1'b1;
            if (apply) begin
                act_word <= stg_word;
                act_mode <= stg_mode;
                pend_q   <= 1'b0;
            end
        end
    end

    AST_ACTIVE_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(act_word) && $stable(act_mode)));                       // R9
    AST_PENDING_DRAINS_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !busy) |=> !pend_q);                                           // R9
endmodule

// File: rtl/csc_row.sv
// One output row: registered products of the three offset-corrected inputs
// (stage 2), then sum with the row constant, round half-up, clamp, and select
// against the carried raw sample for bypass (stage 3). Assumes mode and the
// coefficients are stable while a pixel is inside the row.
module csc_row
    import csc_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int COEF_W = 32,
    parameter int FRAC_W = 17,
    parameter int OFS_W  = 17
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            ld_mul,
    input  logic                            ld_out,
    input  csc_mode_e                       mode,
    input  logic [CSC_CH-1:0][OFS_W-1:0]    ofs,
    input  logic [DATA_W-1:0]               raw,
    input  logic [CSC_CH-1:0][COEF_W-1:0]   gain,
    input  logic [COEF_W/2-1:0]             cst,
    output logic [DATA_W-1:0]               pix_out
);
    localparam int HALF_W = COEF_W / 2;
    localparam int PROD_W = COEF_W + OFS_W;
    localparam int ACC_W  = PROD_W + 2;
    localparam logic signed [ACC_W-1:0] RND  = ACC_W'(1) <<< (FRAC_W - 1);
    localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((1 << DATA_W) - 1);

    logic signed [PROD_W-1:0] prod_d [CSC_CH];
    logic signed [PROD_W-1:0] prod_q [CSC_CH];
    logic        [HALF_W-1:0] cst_q;
    logic        [DATA_W-1:0] raw_q;
    logic signed [ACC_W-1:0]  acc;
    logic signed [ACC_W-1:0]  shr;
    logic        [DATA_W-1:0] sat;

    // Full-width signed products of each gain with its corrected input.
    always_comb begin
        for (int t = 0; t < CSC_CH; t++) begin
            prod_d[t] = $signed({{OFS_W{gain[t][COEF_W-1]}}, gain[t]})
                      * $signed({{COEF_W{ofs[t][OFS_W-1]}}, ofs[t]});
        end
    end

    // Stage 2: register products, the row constant and the raw bypass sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < CSC_CH; t++) prod_q[t] <= '0;
            cst_q <= '0;
            raw_q <= '0;
        end else if (ld_mul) begin
            for (int t = 0; t < CSC_CH; t++) prod_q[t] <= prod_d[t];
            cst_q <= cst;
            raw_q <= raw;
        end
    end

    // Sum, add constant and rounding half, shift out the fraction, saturate.
    always_comb begin
        acc = RND + $signed({{(ACC_W-HALF_W-FRAC_W){cst_q[HALF_W-1]}}, cst_q, {FRAC_W{1'b0}}});
        for (int t = 0; t < CSC_CH; t++) begin
            acc = acc + $signed({{(ACC_W-PROD_W){prod_q[t][PROD_W-1]}}, prod_q[t]});
        end
        shr = acc >>> FRAC_W;
        if (shr[ACC_W-1])     sat = '0;
        else if (shr > MAXV)  sat = '1;
        else                  sat = shr[DATA_W-1:0];
    end

    // Stage 3: output register, converted or raw depending on mode.
    always_ff @(posedge clk) begin
        if (!rst_n)       pix_out <= '0;
        else if (ld_out)  pix_out <= (mode == CSC_APPLY) ? sat : raw_q;
    end

    AST_CLAMP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_out && mode == CSC_APPLY && shr > MAXV) |=> (pix_out == DATA_W'(MAXV)));      // R8
    AST_CLAMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_out && mode == CSC_APPLY && shr[ACC_W-1]) |=> (pix_out == '0));               // R8
endmodule

// File: rtl/csc_matrix.sv
// Top of the colour matrix converter. Stage 1 adds each component's signed
// offset (upper half of that component's row word 3) and keeps the raw
// sample; three csc_row instances then multiply, sum, round and clamp.
// A valid bit travels beside the data. The register bank only swaps in new
// settings while the pipeline is empty.
module csc_matrix
    import csc_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int COEF_W = 32,
    parameter int FRAC_W = 17,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [COEF_W-1:0] cfg_wdata,
    input  logic              cfg_commit,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_c0,
    input  logic [DATA_W-1:0] in_c1,
    input  logic [DATA_W-1:0] in_c2,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_c0,
    output logic [DATA_W-1:0] out_c1,
    output logic [DATA_W-1:0] out_c2
);
    localparam int HALF_W = COEF_W / 2;
    localparam int WIDER  = (DATA_W + 1 > HALF_W) ? DATA_W + 1 : HALF_W;
    localparam int OFS_W  = WIDER + 1;

    logic [CSC_NREG-1:0][COEF_W-1:0] act_word;
    csc_mode_e                       act_mode;
    logic [CSC_CH-1:0][DATA_W-1:0]   in_pix;
    logic [CSC_CH-1:0][OFS_W-1:0]    ofs_d;
    logic [CSC_CH-1:0][OFS_W-1:0]    s1_ofs;
    logic [CSC_CH-1:0][DATA_W-1:0]   s1_raw;
    logic                            v1_q, v2_q, v3_q;
    logic [DATA_W-1:0]               row_out [CSC_CH];

    assign in_pix = {in_c2, in_c1, in_c0};

    csc_regbank #(.COEF_W(COEF_W), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_addr  (cfg_addr),
        .wr_data  (cfg_wdata),
        .commit   (cfg_commit),
        .busy     (in_valid | v1_q | v2_q),
        .act_word (act_word),
        .act_mode (act_mode)
    );

    // Offset correction: zero-extend each sample, add its sign-extended offset.
    always_comb begin
        for (int k = 0; k < CSC_CH; k++) begin
            ofs_d[k] = {{(OFS_W-DATA_W){1'b0}}, in_pix[k]}
                     + {{(OFS_W-HALF_W){act_word[k*CSC_COLS+CSC_COLS-1][COEF_W-1]}},
                        act_word[k*CSC_COLS+CSC_COLS-1][COEF_W-1 -: HALF_W]};
        end
    end

    // Stage 1: register corrected and raw samples for accepted pixels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_ofs <= '0;
            s1_raw <= '0;
        end else if (in_valid) begin
            s1_ofs <= ofs_d;
            s1_raw <= in_pix;
        end
    end

    // Valid pipeline matching the three data stages.
    always_ff @(posedge clk) begin
        if (!rst_n) {v1_q, v2_q, v3_q} <= '0;
        else        {v1_q, v2_q, v3_q} <= {in_valid, v1_q, v2_q};
    end

    for (genvar r = 0; r < CSC_CH; r++) begin : g_row
        csc_row #(.DATA_W(DATA_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W), .OFS_W(OFS_W)) u_row (
            .clk     (clk),
            .rst_n   (rst_n),
            .ld_mul  (v1_q),
            .ld_out  (v2_q),
            .mode    (act_mode),
            .ofs     (s1_ofs),
            .raw     (s1_raw[r]),
            .gain    ({act_word[r*CSC_COLS+2], act_word[r*CSC_COLS+1], act_word[r*CSC_COLS]}),
            .cst     (act_word[r*CSC_COLS+CSC_COLS-1][HALF_W-1:0]),
            .pix_out (row_out[r])
        );
    end

    assign out_valid = v3_q;
    assign out_c0    = row_out[0];
    assign out_c1    = row_out[1];
    assign out_c2    = row_out[2];

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##2 out_valid);                                                  // R2
    AST_BYPASS_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && act_mode == CSC_PASS) |=> ##2
        (out_c0 == $past(in_c0, 3) && out_c1 == $past(in_c1, 3) && out_c2 == $past(in_c2, 3)));   // R3
endmodule

// File: tb/csc_matrix_bench.sv
module csc_matrix_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        cfg_commit = 1'b0;
    logic        in_valid = 1'b0;
    logic [9:0]  in_c0 = '0, in_c1 = '0, in_c2 = '0;
    logic        out_valid;
    logic [9:0]  out_c0, out_c1, out_c2;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] sw [12];
    logic [31:0] cm [12];
    logic        sw_en = 1'b0, cm_en = 1'b0;

    // Fixed program for the table: out0=(x-64)+0.5y, out1=y-z+100, out2=2z-50.
    localparam logic [31:0] PROG [12] = '{
        32'h0002_0000, 32'h0001_0000, 32'h0000_0000, 32'hFFC0_0000,
        32'h0000_0000, 32'h0002_0000, 32'hFFFE_0000, 32'h0000_0064,
        32'h0000_0000, 32'h0000_0000, 32'h0004_0000, 32'h0000_FFCE };
    // x, y, z, expected out0, out1, out2
    localparam int VEC [7][6] = '{
        '{  64,    0,   25,    0,  75,    0},
        '{ 100,    3,   30,   38,  73,   10},
        '{   0,    0,    0,    0, 100,    0},
        '{1023, 1023, 1023, 1023, 100, 1023},
        '{ 500,    5,  600,  439,   0, 1023},
        '{ 200,  401,    0,  337, 501,    0},
        '{  65,    1,  300,    2,   0,  550} };

    always #10 clk = ~clk;

    csc_matrix u_csc_matrix (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_commit(cfg_commit), .in_valid(in_valid), .in_c0(in_c0), .in_c1(in_c1), .in_c2(in_c2),
        .out_valid(out_valid), .out_c0(out_c0), .out_c1(out_c1), .out_c2(out_c2));

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Reference arithmetic written from the requirements, on the committed copy.
    function automatic int model(input int r, input int x, input int y, input int z);
        longint a [3];
        longint acc;
        longint q;
        int     xin [3];
        xin = '{x, y, z};
        if (!cm_en) return xin[r];
        for (int k = 0; k < 3; k++) a[k] = longint'(xin[k]) + longint'($signed(cm[4*k+3][31:16]));
        acc = longint'($signed(cm[4*r+3][15:0])) * 131072 + 65536;
        for (int k = 0; k < 3; k++) acc += longint'($signed(cm[4*r+k])) * a[k];
        q = acc >>> 17;
        if (q < 0) return 0;
        if (q > 1023) return 1023;
        return int'(q);
    endfunction

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a < 12) sw[a] = d;
        else if (a == 12) sw_en = d[0];
    endtask

    task automatic commit_idle();
        @(negedge clk); cfg_commit = 1'b1;
        @(negedge clk); cfg_commit = 1'b0;
        cm = sw; cm_en = sw_en;
    endtask

    task automatic px(input int x, input int y, input int z,
                      output int o0, output int o1, output int o2, output int ov);
        @(negedge clk);
        in_valid = 1'b1; in_c0 = 10'(x); in_c1 = 10'(y); in_c2 = 10'(z);
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk);
        ov = int'(out_valid);
        @(negedge clk);
        ov = ov * 2 + int'(out_valid);
        o0 = int'(out_c0); o1 = int'(out_c1); o2 = int'(out_c2);
    endtask

    task automatic chkpix(input string req, input int x, input int y, input int z);
        int o0, o1, o2, ov;
        px(x, y, z, o0, o1, o2, ov);
        chk(req, "valid timing", ov, 1);
        chk(req, "out_c0", o0, model(0, x, y, z));
        chk(req, "out_c1", o1, model(1, x, y, z));
        chk(req, "out_c2", o2, model(2, x, y, z));
    endtask

    task automatic stream4(input string req, input bit commit_mid);
        for (int j = 0; j < 8; j++) begin
            @(negedge clk);
            if (j >= 3 && j < 7) begin
                chk(req, "stream valid", int'(out_valid), 1);
                chk(req, "stream c0", int'(out_c0), VEC[j-3][3]);
                chk(req, "stream c1", int'(out_c1), VEC[j-3][4]);
                chk(req, "stream c2", int'(out_c2), VEC[j-3][5]);
            end
            if (j == 7) chk(req, "valid low after burst", int'(out_valid), 0);
            cfg_commit = commit_mid && (j == 1);
            if (j < 4) begin
                in_valid = 1'b1;
                in_c0 = 10'(VEC[j][0]); in_c1 = 10'(VEC[j][1]); in_c2 = 10'(VEC[j][2]);
            end else begin
                in_valid = 1'b0;
            end
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
        $finish;
    end

    initial begin
        int o0, o1, o2, ov;
        for (int i = 0; i < 12; i++) begin sw[i] = '0; cm[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "out_valid after reset", int'(out_valid), 0);
        chk("R1", "out_c0 after reset", int'(out_c0), 0);
        chk("R1", "out_c2 after reset", int'(out_c2), 0);
        // R1, R3: unprogrammed unit passes samples through
        chkpix("R1", 5, 700, 1023);

        // R9: staged but uncommitted program leaves bypass in force
        for (int i = 0; i < 12; i++) wr(i, PROG[i]);
        wr(12, 32'h1);
        px(100, 3, 30, o0, o1, o2, ov);
        chk("R9", "uncommitted c0", o0, 100);
        chk("R9", "uncommitted c1", o1, 3);
        chk("R9", "uncommitted c2", o2, 30);
        commit_idle();

        // R5 R6 R7 R8: table walk
        for (int v = 0; v < 7; v++) begin
            px(VEC[v][0], VEC[v][1], VEC[v][2], o0, o1, o2, ov);
            chk("R2", "table valid", ov, 1);
            chk("R5", "table c0", o0, VEC[v][3]);
            chk("R6", "table c1", o1, VEC[v][4]);
            chk("R8", "table c2", o2, VEC[v][5]);
        end

        // R2: back-to-back burst
        stream4("R2", 1'b0);

        // R9: commit mid-stream held until drained
        wr(7, 32'h0000_0000);
        stream4("R9", 1'b1);
        cm = sw; cm_en = sw_en;
        chkpix("R9", 200, 401, 0);
        chk("R9", "new constant reached c1", model(1, 200, 401, 0), 401);

        // R10: column swap routes the half gain to input 2
        wr(1, 32'h0000_0000);
        wr(2, 32'h0001_0000);
        commit_idle();
        px(100, 7, 30, o0, o1, o2, ov);
        chk("R10", "swapped c0", o0, 51);

        // R11: writes above the control word are ignored
        wr(13, 32'hFFFF_FFFF);
        wr(14, 32'h0000_0000);
        wr(15, 32'hFFFF_FFFF);
        commit_idle();
        chkpix("R11", 100, 7, 30);

        // R4 R5: limited-range luma/chroma program
        wr(0, 32'h0002_542A); wr(1, 32'h0000_0000); wr(2, 32'h0003_95E2); wr(3, 32'hFFC0_0000);
        wr(4, 32'h0002_542A); wr(5, 32'hFFFF_92D2); wr(6, 32'hFFFE_EF27); wr(7, 32'hFE00_0000);
        wr(8, 32'h0002_542A); wr(9, 32'h0004_398C); wr(10, 32'h0000_0000); wr(11, 32'hFE00_0000);
        commit_idle();
        px(940, 512, 512, o0, o1, o2, ov);
        chk("R4", "white c0", o0, 1020);
        chk("R4", "white c1", o1, 1020);
        chk("R4", "white c2", o2, 1020);
        px(64, 512, 512, o0, o1, o2, ov);
        chk("R5", "black c0", o0, 0);
        chk("R5", "black c1", o1, 0);
        chk("R5", "black c2", o2, 0);
        chkpix("R5", 300, 200, 700);
        chkpix("R7", 500, 800, 300);

        // R3: disable returns to bypass
        wr(12, 32'h0);
        commit_idle();
        chkpix("R3", 17, 1000, 512);

        summary();
        $finish;
    end
endmodule